// File: doc/BRIEF.md
# Posted Write Tracker

This block carries register writes from a fast bus clock into a slower functional clock. It holds a bank of 32-bit functional registers, and each register has its own single-bit request/acknowledge channel. A bus write captures its data in a holding register on the bus side. It then starts a four-phase handshake, and the functional side copies the held value once the request has been synchronized. A read-only status word shows, per register, whether a write is still in flight.

Two behaviours are available, chosen by a configuration bit. In posted mode the bus sees every write complete in the cycle it is issued. In non-posted mode the bus ready signal is held low until that write's handshake has fully returned to idle. A second configuration bit is a self-clearing soft reset that clears every functional register through its own handshake channel. A write aimed at a register that is still pending is discarded and raises a sticky error flag. A reduced build without the extended registers keeps only the first five channels.

Top module: `posted_write_tracker`

## Requirements
- R1: After reset, the status word is 0, the error flag is 0, ready is 1, configuration readback is 2'b01 (bit 0 = posted, bit 1 = soft reset), and all functional registers are 0.
- R2: Status bit positions are: 0 control, 1 counter, 2 load, 3 trigger, 4 match, 5 positive increment, 6 negative increment, 7 counter value, 8 overflow count, 9 overflow wrap. A bit reads 1 from the bus cycle after a write to that register is accepted until its handshake has returned to idle, and 0 otherwise.
- R3: In posted mode (configuration bit 0 = 1, its reset value), ready stays 1 and each cycle with wr_en high is one write. Once the register's status bit is back at 0, the functional register holds the written value, and it is taken exactly once.
- R4: In non-posted mode (configuration bit 0 = 0), ready reads 0 from the cycle after a write is issued until the handshake completes. Ready is then 1 for one cycle, and in that cycle the value is in place and the status bit is 0. Configuration readback bit 0 follows the mode.
- R5: The status word reads nonzero whenever any write is outstanding.
- R6: Writing configuration bit 1 = 1 clears all functional registers. Configuration readback bit 1 always reads 0, and the same write still applies bit 0.
- R7: With EXT_REGS = 0, status bits 5 to 9 always read 0 and writes to indices 5 to 9 are ignored, with no error. In any build, an index at or above the register count is ignored without an error.
- R8: A write to a register whose status bit is 1 is dropped and the first value is kept. The error flag becomes 1 in the next cycle and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| clk_fn | input | 1 | Functional clock |
| rst_fn | input | 1 | Synchronous active-high reset, functional domain |
| wr_en | input | 1 | Register write request |
| wr_idx | input | 4 | Target register index |
| wr_data | input | 32 | Write data |
| bus_ready | output | 1 | Write completion toward the bus |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2 | Bit 0 posted mode, bit 1 soft reset |
| cfg_rdata | output | 2 | Configuration readback (bit 1 always 0) |
| pend_status | output | 10 | Per-register write-pending flags |
| wr_err | output | 1 | Sticky dropped-write flag |
| fn_regs | output | 320 | Functional registers, register i at bits i*32 +: 32 |

## Verification
The hardest condition to reach from the ports is a write that lands while the same register's handshake is still running. The bench creates it by issuing two writes to one index in consecutive bus cycles, which is far shorter than the synchronizer round trip through the slower clock. The reference model then requires the first value to survive and the error flag to rise. A stalled non-posted write is reached by clearing the mode bit and holding wr_en until ready returns. The bench also drives a reduced build with the same stimulus, so that writes to the absent extended registers can be seen to be ignored.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    localparam int PWT_NREG  = 10;
    localparam int PWT_NBASE = 5;
    localparam int PWT_DW    = 32;

    localparam int CFG_POSTED_BIT = 0;
    localparam int CFG_SRST_BIT   = 1;

    typedef enum logic [1:0] {
        NP_IDLE = 2'd0,
        NP_WAIT = 2'd1,
        NP_DONE = 2'd2
    } np_state_e;

    function automatic int active_count(input bit ext, input int full, input int base);
        return ext ? full : base;
    endfunction

endpackage

// File: rtl/pwt_sync.sv
module pwt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pwt_hs_chan.sv
module pwt_hs_chan #(
    parameter int STAGES = 2
) (
    input  logic clk_bus,
    input  logic rst_bus,
    input  logic launch,
    output logic pend,
    input  logic clk_fn,
    input  logic rst_fn,
    output logic take
);
    logic req_q, ack_s, req_s, ack_q;

    // bus side: raise request, drop it once acknowledge is seen
    always_ff @(posedge clk_bus) begin
        if (rst_bus)             req_q <= 1'b0;
        else if (launch)         req_q <= 1'b1;
        else if (req_q && ack_s) req_q <= 1'b0;
    end

    pwt_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk(clk_bus), .rst(rst_bus), .d(ack_q), .q(ack_s)
    );

    pwt_sync #(.STAGES(STAGES)) u_req_sync (
        .clk(clk_fn), .rst(rst_fn), .d(req_q), .q(req_s)
    );

    // functional side: acknowledge follows the synchronized request
    always_ff @(posedge clk_fn) begin
        if (rst_fn)               ack_q <= 1'b0;
        else if (req_s && !ack_q) ack_q <= 1'b1;
        else if (!req_s && ack_q) ack_q <= 1'b0;
    end

    assign take = req_s & ~ack_q;
    assign pend = req_q | ack_s;

    AST_PEND_AFTER_LAUNCH: assert property (@(posedge clk_bus) disable iff (rst_bus)
        launch |=> pend); // R2
    AST_LAUNCH_WHEN_IDLE: assert property (@(posedge clk_bus) disable iff (rst_bus)
        launch |-> !pend); // R8
    AST_TAKE_ONCE: assert property (@(posedge clk_fn) disable iff (rst_fn)
        take |=> !take); // R3
endmodule

// File: rtl/pwt_bus_ctl.sv
module pwt_bus_ctl
    import pwt_pkg::*;
#(
    parameter int NREG = 10,
    parameter int NACT = 10,
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_wdata,
    input  logic [NREG-1:0] pend,
    input  logic            srst_pend,
    output logic [NREG-1:0] launch,
    output logic            srst_launch,
    output logic            bus_ready,
    output logic            wr_err,
    output logic            posted
);
    np_state_e       st_q;
    logic [IDXW-1:0] held_q;
    logic            posted_q, err_q;
    logic            fire, idx_ok, busy, go, drop;

    function automatic logic sel_bit(input logic [NREG-1:0] v, input logic [IDXW-1:0] idx);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NREG; i++)
            if (idx == IDXW'(i)) r = v[i];
        return r;
    endfunction

    always_comb begin
        fire   = wr_en && (posted_q || st_q == NP_IDLE);
        idx_ok = int'(wr_idx) < NACT;
        busy   = sel_bit(pend, wr_idx);
        go     = fire && idx_ok && !busy;
        drop   = fire && idx_ok && busy;
        for (int i = 0; i < NREG; i++)
            launch[i] = go && (wr_idx == IDXW'(i));
    end

    assign srst_launch = cfg_we && cfg_wdata[CFG_SRST_BIT] && !srst_pend;
    assign bus_ready   = posted_q || (st_q == NP_DONE);
    assign wr_err      = err_q;
    assign posted      = posted_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= NP_IDLE;
            held_q   <= '0;
            posted_q <= 1'b1;
            err_q    <= 1'b0;
        end else begin
            if (cfg_we) posted_q <= cfg_wdata[CFG_POSTED_BIT];
            if (drop)   err_q    <= 1'b1;
            if (posted_q) begin
                st_q <= NP_IDLE;
            end else begin
                case (st_q)
                    NP_IDLE: if (wr_en) begin
                        held_q <= wr_idx;
                        st_q   <= go ? NP_WAIT : NP_DONE;
                    end
                    NP_WAIT: if (!sel_bit(pend, held_q)) st_q <= NP_DONE;
                    default: st_q <= NP_IDLE;
                endcase
            end
        end
    end

    AST_DROP_RAISES_ERR: assert property (@(posedge clk) disable iff (rst)
        drop |=> wr_err); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> wr_err); // R8
    AST_NP_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (st_q == NP_DONE && $past(st_q) == NP_WAIT) |-> !sel_bit(pend, held_q)); // R4
    AST_SRST_ONESHOT: assert property (@(posedge clk) disable iff (rst)
        srst_launch |=> !srst_launch); // R6
endmodule

// File: rtl/posted_write_tracker.sv
module posted_write_tracker
    import pwt_pkg::*;
#(
    parameter int NREG        = PWT_NREG,
    parameter int NBASE       = PWT_NBASE,
    parameter int DW          = PWT_DW,
    parameter bit EXT_REGS    = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk_bus,
    input  logic                    rst_bus,
    input  logic                    clk_fn,
    input  logic                    rst_fn,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [DW-1:0]           wr_data,
    output logic                    bus_ready,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_wdata,
    output logic [1:0]              cfg_rdata,
    output logic [NREG-1:0]         pend_status,
    output logic                    wr_err,
    output logic [NREG*DW-1:0]      fn_regs
);
    localparam int NACT = active_count(EXT_REGS, NREG, NBASE);
    localparam int IDXW = $clog2(NREG);

    logic [NREG-1:0]    launch, pend, take;
    logic [NREG*DW-1:0] hold_flat;
    logic               srst_launch, srst_pend, srst_take, posted;
    logic [DW-1:0]      fn_q [NREG];

    pwt_bus_ctl #(.NREG(NREG), .NACT(NACT), .IDXW(IDXW)) u_ctl (
        .clk(clk_bus), .rst(rst_bus), .wr_en(wr_en), .wr_idx(wr_idx),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .pend(pend), .srst_pend(srst_pend),
        .launch(launch), .srst_launch(srst_launch), .bus_ready(bus_ready),
        .wr_err(wr_err), .posted(posted)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g < NACT) begin : g_live
            logic [DW-1:0] hold_r;
            always_ff @(posedge clk_bus) begin
                if (rst_bus)        hold_r <= '0;
                else if (launch[g]) hold_r <= wr_data;
            end
            assign hold_flat[g*DW +: DW] = hold_r;
            pwt_hs_chan #(.STAGES(SYNC_STAGES)) u_chan (
                .clk_bus(clk_bus), .rst_bus(rst_bus), .launch(launch[g]), .pend(pend[g]),
                .clk_fn(clk_fn), .rst_fn(rst_fn), .take(take[g])
            );
        end else begin : g_void
            assign hold_flat[g*DW +: DW] = '0;
            assign pend[g] = 1'b0;
            assign take[g] = 1'b0;
        end
        assign fn_regs[g*DW +: DW] = fn_q[g];
    end

    pwt_hs_chan #(.STAGES(SYNC_STAGES)) u_srst_chan (
        .clk_bus(clk_bus), .rst_bus(rst_bus), .launch(srst_launch), .pend(srst_pend),
        .clk_fn(clk_fn), .rst_fn(rst_fn), .take(srst_take)
    );

    // functional register bank: soft reset wins over a same-cycle take
    always_ff @(posedge clk_fn) begin
        if (rst_fn || srst_take) begin
            for (int i = 0; i < NREG; i++) fn_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++)
                if (take[i]) fn_q[i] <= hold_flat[i*DW +: DW];
        end
    end

    assign cfg_rdata   = {1'b0, posted};
    assign pend_status = pend;

    AST_SRST_CLEARS: assert property (@(posedge clk_fn) disable iff (rst_fn)
        srst_take |=> (fn_regs == '0)); // R6
endmodule

// File: tb/posted_write_tracker_tb_top.sv
module posted_write_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FN_PERIOD  = 26;
    localparam int NREG = 10;
    localparam int DW   = 32;

    logic clk_bus = 1'b0, clk_fn = 1'b0, rst = 1'b1;
    logic wr_en = 1'b0, cfg_we = 1'b0;
    logic [3:0] wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0] cfg_wdata = '0;

    logic ready_a, ready_b, err_a, err_b;
    logic [1:0] cfg_a, cfg_b;
    logic [NREG-1:0] pend_a, pend_b;
    logic [NREG*DW-1:0] regs_a, regs_b;

    int compared = 0, mismatched = 0;
    logic [DW-1:0] exp_val [NREG];
    bit m_err = 1'b0, m_posted = 1'b1, mon_on = 1'b0;
    int srst_win = 0;

    always #(CLK_PERIOD/2) clk_bus = ~clk_bus;
    always #(FN_PERIOD/2)  clk_fn  = ~clk_fn;

    posted_write_tracker dut_i (
        .clk_bus(clk_bus), .rst_bus(rst), .clk_fn(clk_fn), .rst_fn(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .bus_ready(ready_a),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_a),
        .pend_status(pend_a), .wr_err(err_a), .fn_regs(regs_a)
    );

    posted_write_tracker #(.EXT_REGS(1'b0)) dut_lite_i (
        .clk_bus(clk_bus), .rst_bus(rst), .clk_fn(clk_fn), .rst_fn(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .bus_ready(ready_b),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_b),
        .pend_status(pend_b), .wr_err(err_b), .fn_regs(regs_b)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] reg_of(input logic [NREG*DW-1:0] v, input int i);
        return v[i*DW +: DW];
    endfunction

    // reference comparison on every bus clock
    always @(negedge clk_bus) begin
        if (mon_on) begin
            chk(err_a == m_err, "R8", "error flag full", 32'(err_a), 32'(m_err));
            chk(err_b == m_err, "R8", "error flag lite", 32'(err_b), 32'(m_err));
            if (m_posted) begin
                chk(ready_a, "R3", "posted ready full", 32'(ready_a), 1);
                chk(ready_b, "R3", "posted ready lite", 32'(ready_b), 1);
            end
            chk(pend_b[9:5] == '0, "R7", "lite reserved bits", 32'(pend_b), 0);
            chk(cfg_a[1] == 1'b0 && cfg_b[1] == 1'b0, "R6", "soft reset readback", 32'(cfg_a), 0);
            chk(cfg_a[0] == m_posted, "R4", "mode readback", 32'(cfg_a[0]), 32'(m_posted));
            if (srst_win > 0) srst_win--;
            else begin
                for (int i = 0; i < NREG; i++) begin
                    if (!pend_a[i])
                        chk(reg_of(regs_a, i) == exp_val[i], "R3", $sformatf("full reg %0d", i),
                            reg_of(regs_a, i), exp_val[i]);
                    if (!pend_b[i])
                        chk(reg_of(regs_b, i) == ((i < 5) ? exp_val[i] : '0), "R7",
                            $sformatf("lite reg %0d", i), reg_of(regs_b, i),
                            (i < 5) ? exp_val[i] : '0);
                end
            end
        end
    end

    task automatic post_write(input int idx, input logic [DW-1:0] d, input bit drop);
        wr_idx = 4'(idx); wr_data = d; wr_en = 1'b1;
        @(posedge clk_bus); #1;
        wr_en = 1'b0;
        if (drop) m_err = 1'b1;
        if (idx < NREG) begin
            if (!drop) exp_val[idx] = d;
            chk(pend_a[idx], "R2", $sformatf("pending bit %0d set", idx), 32'(pend_a), 32'(1 << idx));
            chk(pend_a != '0, "R5", "status nonzero", 32'(pend_a), 1);
        end
    endtask

    task automatic cfg_write(input logic [1:0] v);
        cfg_wdata = v; cfg_we = 1'b1;
        @(posedge clk_bus); #1;
        cfg_we = 1'b0;
        m_posted = v[0];
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((pend_a != '0 || pend_b != '0) && n < 300) begin
            @(posedge clk_bus); #1; n++;
        end
        chk(n < 300, "R2", "handshake returns idle", n, 300);
        repeat (2) @(posedge clk_bus);
        #1;
    endtask

    task automatic np_write(input int idx, input logic [DW-1:0] d);
        int n = 0;
        wr_idx = 4'(idx); wr_data = d; wr_en = 1'b1;
        @(posedge clk_bus); #1;
        exp_val[idx] = d;
        chk(!ready_a, "R4", "ready low while stalled", 32'(ready_a), 0);
        while (!ready_a && n < 300) begin
            @(posedge clk_bus); #1; n++;
        end
        chk(n >= 2 && n < 300, "R4", "stall length", n, 2);
        chk(!pend_a[idx], "R4", "pending clear at ready", 32'(pend_a), 0);
        chk(reg_of(regs_a, idx) == d, "R4", "value in place at ready", reg_of(regs_a, idx), d);
        chk(ready_b, "R4", "lite ready in step", 32'(ready_b), 1);
        @(posedge clk_bus); #1;
        wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) exp_val[i] = '0;
        repeat (20) @(posedge clk_bus);
        #1 rst = 1'b0;
        // R1 reset state
        chk(pend_a == '0 && pend_b == '0, "R1", "status after reset", 32'(pend_a), 0);
        chk(!err_a, "R1", "error after reset", 32'(err_a), 0);
        chk(ready_a, "R1", "ready after reset", 32'(ready_a), 1);
        chk(cfg_a == 2'b01, "R1", "config after reset", 32'(cfg_a), 1);
        chk(regs_a == '0, "R1", "registers after reset", regs_a[31:0], 0);
        mon_on = 1'b1;

        // R3: one write per register, consecutive cycles
        for (int i = 0; i < NREG; i++) post_write(i, 32'hA5000000 + 32'(i * 32'h01010101), 1'b0);
        wait_idle();
        post_write(4, 32'hFFFFFFFF, 1'b0);
        post_write(0, 32'h00000000, 1'b0);
        post_write(9, 32'h55AA55AA, 1'b0);
        wait_idle();

        // R8: second write while pending is dropped
        post_write(2, 32'h12345678, 1'b0);
        post_write(2, 32'h87654321, 1'b1);
        wait_idle();
        chk(reg_of(regs_a, 2) == 32'h12345678, "R8", "first value kept", reg_of(regs_a, 2), 32'h12345678);

        // R7: index 7 absent in lite build, index 12 absent everywhere
        post_write(7, 32'hC0FFEE00, 1'b0);
        chk(pend_b == '0, "R7", "lite ignores index 7", 32'(pend_b), 0);
        wait_idle();
        post_write(12, 32'hDEADBEEF, 1'b0);
        chk(pend_a == '0, "R7", "out of range ignored", 32'(pend_a), 0);
        wait_idle();

        // R4: non-posted writes
        cfg_write(2'b00);
        np_write(3, 32'h0BADF00D);
        np_write(3, 32'h600DCAFE);
        np_write(1, 32'h13579BDF);
        cfg_write(2'b01);
        wait_idle();

        // R6: soft reset, then life after it
        cfg_write(2'b11);
        srst_win = 60;
        for (int i = 0; i < NREG; i++) exp_val[i] = '0;
        chk(cfg_a == 2'b01, "R6", "soft reset bit reads 0", 32'(cfg_a), 1);
        repeat (70) @(posedge clk_bus);
        #1;
        chk(regs_a == '0 && regs_b == '0, "R6", "registers cleared", regs_a[31:0], 0);
        post_write(1, 32'h2468ACE0, 1'b0);
        wait_idle();
        cfg_write(2'b11);
        srst_win = 60;
        for (int i = 0; i < NREG; i++) exp_val[i] = '0;
        repeat (70) @(posedge clk_bus);
        #1;
        chk(reg_of(regs_a, 1) == '0, "R6", "second soft reset", reg_of(regs_a, 1), 0);

        repeat (5) @(posedge clk_bus);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule